// File: doc/BRIEF.md
# USB Receiver Line State Event Detector

This block watches the two single-ended receiver outputs of a USB port, one saying the D+ wire is high and one saying the D- wire is high. It brings both wires and a speed-select input through a two-stage synchronizer, then sorts every clock sample into one of four line conditions: J, K, both-low (SE0) or both-high (SE1, an illegal condition reported as its own code). The J/K meaning of a given wire pair is inverted between full-speed and low-speed operation.

From the stream of line conditions it produces one-clock event pulses: start of packet (idle J turning into K), end of packet (an SE0 of at least one bit time followed by J), and, depending on which side of the cable the port faces, bus reset (device side) or connect and disconnect (host side, facing a device). Every duration is counted in clock cycles derived from a clock-frequency parameter, so the same RTL serves any system clock. The registered line code is exported so that downstream receive logic can follow the bus.

Top module: `usb_line_event_det`

## Requirements
- R1: With the speed input low (full speed), D+ high and D- low gives line code 2'b01 (J), D- high and D+ low gives 2'b10 (K), both low gives 2'b00 (SE0) and both high gives 2'b11 (SE1); the code appears on the output three clock edges after the wires change.
- R2: With the speed input high (low speed), D+ high and D- low gives K (2'b10) and D- high and D+ low gives J (2'b01); SE0 and SE1 codes are unchanged.
- R3: A start-of-packet pulse is raised in the same cycle that the line code changes from J to K, and not for a change into K from any other condition.
- R4: An end-of-packet pulse is raised in the cycle the line code changes from SE0 to J, only if SE0 lasted at least one bit time (CLK_MHZ/12 cycles at full speed, 4 at the default; CLK_MHZ*2/3 at low speed, 32 at the default); a shorter SE0, or SE0 followed by K, gives no pulse.
- R5: With UPSTREAM = 0, a bus-reset pulse is raised in the cycle the line code has shown SE0 for CLK_MHZ*2.5 consecutive cycles (120 at the default, i.e. 2.5 us), at most once per SE0 run; an SE0 of 119 cycles gives none.
- R6: With UPSTREAM = 1, while not connected, a connect pulse is raised when the line code has shown anything but SE0 for 120 consecutive cycles; the port is then connected.
- R7: With UPSTREAM = 1, while connected, a disconnect pulse is raised when the line code has shown SE0 for 120 consecutive cycles; the port is then not connected and no further disconnect occurs until a new connect.
- R8: With UPSTREAM = 0 the connect and disconnect outputs never pulse; with UPSTREAM = 1 the bus-reset output never pulses.
- R9: While rst_n is low the line code is SE0 and every event output is low.
- R10: Every event output is high for exactly one clock per qualifying condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dpHigh | input | 1 | Receiver comparator: D+ above threshold (asynchronous) |
| dmHigh | input | 1 | Receiver comparator: D- above threshold (asynchronous) |
| lowSpeed | input | 1 | 1 selects low-speed J/K mapping and bit time |
| lineState | output | 2 | Registered line code: 00 SE0, 01 J, 10 K, 11 SE1 |
| sopPulse | output | 1 | Start-of-packet event |
| eopPulse | output | 1 | End-of-packet event |
| busResetPulse | output | 1 | Bus reset recognized (device side only) |
| connectPulse | output | 1 | Device attach recognized (host side only) |
| disconnectPulse | output | 1 | Device detach recognized (host side only) |

## Verification
A wire change applied between edges shows up on the line code, and the start- and end-of-packet pulses fire, in the cycle after the third following edge; the driver computes that cycle for each stimulus segment and the monitor compares the pulses exactly there. Duration events are due 119 cycles after the first cycle the qualifying condition is visible, minus any run already accumulated for connect, so the driver schedules them at that absolute cycle and the scoreboard flags both a pulse that is missing at its cycle and one that appears at any other cycle. The boundary runs (3 and 4 cycles, 31 and 32 cycles, 119 and 120 cycles) sit on either side of each threshold.

// File: rtl/usb_lse_pkg.sv
package usb_lse_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_e;

  // Status from datapath to control
  typedef struct packed {
    line_e nextLine;   // classification of the synchronized sample
    line_e curLine;    // registered classification
    logic  se0Enough;  // current SE0 run is at least one bit time
    logic  se0Long;    // SE0 continues and reaches the long threshold this cycle or later
    logic  actLong;    // non-SE0 continues and reaches the long threshold this cycle or later
  } dpStat_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic sop;
    logic eop;
    logic busReset;
    logic connect;
    logic disconnect;
  } evtStrobe_t;

endpackage

// File: rtl/usb_lse_sync.sv
module usb_lse_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain <= {chain[STAGES-2:0], din[gi]};
        end
      end
      assign dout[gi] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/usb_lse_classify.sv
module usb_lse_classify
  import usb_lse_pkg::*;
(
  input  logic  dpIn,
  input  logic  dmIn,
  input  logic  slowMode,
  output line_e lineOut
);

  always_comb begin
    unique case ({dpIn, dmIn})
      2'b00:   lineOut = LINE_SE0;
      2'b11:   lineOut = LINE_SE1;
      2'b10:   lineOut = slowMode ? LINE_K : LINE_J;
      default: lineOut = slowMode ? LINE_J : LINE_K;
    endcase
  end

endmodule

// File: rtl/usb_lse_datapath.sv
module usb_lse_datapath
  import usb_lse_pkg::*;
#(
  parameter int CLK_MHZ = 48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dpRaw,
  input  logic       dmRaw,
  input  logic       lowSpeedRaw,
  input  evtStrobe_t strobe,
  output dpStat_t    stat,
  output logic [1:0] lineCode,
  output logic       sopQ,
  output logic       eopQ,
  output logic       busResetQ,
  output logic       connectQ,
  output logic       disconnectQ
);

  // Cycle counts derived from the clock frequency
  localparam int FS_BIT  = (CLK_MHZ + 11) / 12;       // 12 Mb/s bit
  localparam int LS_BIT  = (CLK_MHZ * 2 + 2) / 3;     // 1.5 Mb/s bit
  localparam int LONG_CY = (CLK_MHZ * 5 + 1) / 2;     // 2.5 us
  localparam int RUN_MAX = (LONG_CY > LS_BIT) ? LONG_CY : LS_BIT;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [2:0]       rawVec;
  logic [2:0]       syncVec;
  line_e            nextLine;
  line_e            curLine;
  logic [RUN_W-1:0] se0Run;
  logic [RUN_W-1:0] actRun;
  logic [RUN_W-1:0] bitCycles;

  assign rawVec = {lowSpeedRaw, dmRaw, dpRaw};

  usb_lse_sync #(
    .WIDTH (3),
    .STAGES(2)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rawVec),
    .dout (syncVec)
  );

  usb_lse_classify u_classify (
    .dpIn    (syncVec[0]),
    .dmIn    (syncVec[1]),
    .slowMode(syncVec[2]),
    .lineOut (nextLine)
  );

  function automatic logic [RUN_W-1:0] satInc(input logic [RUN_W-1:0] v);
    return (v == RUN_W'(RUN_MAX)) ? v : v + RUN_W'(1);
  endfunction

  // Line register and run-length counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curLine <= LINE_SE0;
      se0Run  <= '0;
      actRun  <= '0;
    end else begin
      curLine <= nextLine;
      se0Run  <= (nextLine == LINE_SE0) ? satInc(se0Run) : '0;
      actRun  <= (nextLine != LINE_SE0) ? satInc(actRun) : '0;
    end
  end

  assign bitCycles = syncVec[2] ? RUN_W'(LS_BIT) : RUN_W'(FS_BIT);

  always_comb begin
    stat.nextLine  = nextLine;
    stat.curLine   = curLine;
    stat.se0Enough = (se0Run >= bitCycles);
    stat.se0Long   = (nextLine == LINE_SE0) && (se0Run >= RUN_W'(LONG_CY - 1));
    stat.actLong   = (nextLine != LINE_SE0) && (actRun >= RUN_W'(LONG_CY - 1));
  end

  // Event output registers, aligned with the line register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sopQ        <= 1'b0;
      eopQ        <= 1'b0;
      busResetQ   <= 1'b0;
      connectQ    <= 1'b0;
      disconnectQ <= 1'b0;
    end else begin
      sopQ        <= strobe.sop;
      eopQ        <= strobe.eop;
      busResetQ   <= strobe.busReset;
      connectQ    <= strobe.connect;
      disconnectQ <= strobe.disconnect;
    end
  end

  assign lineCode = curLine;

endmodule

// File: rtl/usb_lse_control.sv
module usb_lse_control
  import usb_lse_pkg::*;
#(
  parameter bit UPSTREAM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dpStat_t    stat,
  output evtStrobe_t strobe
);

  logic resetArmed;
  logic connected;
  logic rawSop;
  logic rawEop;
  logic rawReset;
  logic rawConnect;
  logic rawDisconnect;

  assign rawSop = (stat.nextLine == LINE_K) && (stat.curLine == LINE_J);
  assign rawEop = (stat.nextLine == LINE_J) && (stat.curLine == LINE_SE0) && stat.se0Enough;

  // One reset event per SE0 run; re-armed once SE0 is gone
  assign rawReset = stat.se0Long && resetArmed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resetArmed <= 1'b1;
    end else if (rawReset) begin
      resetArmed <= 1'b0;
    end else if (stat.nextLine != LINE_SE0) begin
      resetArmed <= 1'b1;
    end
  end

  // Attachment tracking
  assign rawConnect    = stat.actLong && !connected;
  assign rawDisconnect = stat.se0Long && connected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      connected <= 1'b0;
    end else if (rawConnect) begin
      connected <= 1'b1;
    end else if (rawDisconnect) begin
      connected <= 1'b0;
    end
  end

  // Port-facing variant picks which duration events are reported
  logic modeReset;
  logic modeConnect;
  logic modeDisconnect;

  generate
    if (UPSTREAM) begin : g_host_side
      assign modeReset      = 1'b0;
      assign modeConnect    = rawConnect;
      assign modeDisconnect = rawDisconnect;
    end else begin : g_device_side
      assign modeReset      = rawReset;
      assign modeConnect    = 1'b0;
      assign modeDisconnect = 1'b0;
    end
  endgenerate

  always_comb begin
    strobe.sop        = rawSop;
    strobe.eop        = rawEop;
    strobe.busReset   = modeReset;
    strobe.connect    = modeConnect;
    strobe.disconnect = modeDisconnect;
  end

endmodule

// File: rtl/usb_line_event_det.sv
module usb_line_event_det
  import usb_lse_pkg::*;
#(
  parameter int CLK_MHZ  = 48,
  parameter bit UPSTREAM = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dpHigh,
  input  logic       dmHigh,
  input  logic       lowSpeed,
  output logic [1:0] lineState,
  output logic       sopPulse,
  output logic       eopPulse,
  output logic       busResetPulse,
  output logic       connectPulse,
  output logic       disconnectPulse
);

  dpStat_t    dpStat;
  evtStrobe_t ctlStrobe;

  usb_lse_datapath #(
    .CLK_MHZ(CLK_MHZ)
  ) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .dpRaw      (dpHigh),
    .dmRaw      (dmHigh),
    .lowSpeedRaw(lowSpeed),
    .strobe     (ctlStrobe),
    .stat       (dpStat),
    .lineCode   (lineState),
    .sopQ       (sopPulse),
    .eopQ       (eopPulse),
    .busResetQ  (busResetPulse),
    .connectQ   (connectPulse),
    .disconnectQ(disconnectPulse)
  );

  usb_lse_control #(
    .UPSTREAM(UPSTREAM)
  ) u_control (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (dpStat),
    .strobe(ctlStrobe)
  );

endmodule

// File: rtl/usb_line_event_chk.sv
module usb_line_event_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dpHigh,
  input logic       dmHigh,
  input logic       lowSpeed,
  input logic [1:0] lineState,
  input logic       sopPulse,
  input logic       eopPulse,
  input logic       busResetPulse,
  input logic       connectPulse,
  input logic       disconnectPulse
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceRst <= '0;
    end else if (sinceRst != 3'd7) begin
      sinceRst <= sinceRst + 3'd1;
    end
  end

  // R1 / R2: classification three edges after the wires
  assert_dp_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd5 && $past(dpHigh, 3) && !$past(dmHigh, 3))
      |-> (lineState == ($past(lowSpeed, 3) ? 2'b10 : 2'b01)));

  assert_dm_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 3'd5 && !$past(dpHigh, 3) && $past(dmHigh, 3))
      |-> (lineState == ($past(lowSpeed, 3) ? 2'b01 : 2'b10)));

  // R3: start of packet only on J to K
  assert_sop_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sopPulse |-> (lineState == 2'b10 && $past(lineState) == 2'b01));

  // R4: end of packet only on SE0 to J
  assert_eop_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eopPulse |-> (lineState == 2'b01 && $past(lineState) == 2'b00));

  // R5 / R7: long-SE0 events only while SE0 is shown
  assert_reset_se0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busResetPulse |-> (lineState == 2'b00));

  assert_disc_se0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disconnectPulse |-> (lineState == 2'b00));

  // R6: connect only while a line is high
  assert_conn_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    connectPulse |-> (lineState != 2'b00));

  // R8: reset and attach events never together
  assert_mode_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busResetPulse, connectPulse, disconnectPulse}) <= 1);

  // R10: single-cycle pulses
  assert_sop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sopPulse |=> !sopPulse);
  assert_eop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eopPulse |=> !eopPulse);
  assert_reset_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busResetPulse |=> !busResetPulse);
  assert_conn_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    connectPulse |=> !connectPulse);
  assert_disc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    disconnectPulse |=> !disconnectPulse);

endmodule

bind usb_line_event_det usb_line_event_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dpHigh         (dpHigh),
  .dmHigh         (dmHigh),
  .lowSpeed       (lowSpeed),
  .lineState      (lineState),
  .sopPulse       (sopPulse),
  .eopPulse       (eopPulse),
  .busResetPulse  (busResetPulse),
  .connectPulse   (connectPulse),
  .disconnectPulse(disconnectPulse)
);

// File: tb/usb_line_event_det_bench.sv
`timescale 1ns/1ps
module usb_line_event_det_bench;

  localparam int FS_BIT = 4;
  localparam int LS_BIT = 32;
  localparam int LIM    = 120;
  localparam int C_SE0 = 0, C_J = 1, C_K = 2, C_SE1 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b0, ls = 1'b0;

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0] devLine, upLine;
  logic devSop, devEop, devRst, devConn, devDisc;
  logic upSop, upEop, upRst, upConn, upDisc;

  usb_line_event_det #(.CLK_MHZ(48), .UPSTREAM(1'b0)) u_usb_line_event_det (
    .clk(clk), .rst_n(rst_n), .dpHigh(dp), .dmHigh(dm), .lowSpeed(ls),
    .lineState(devLine), .sopPulse(devSop), .eopPulse(devEop),
    .busResetPulse(devRst), .connectPulse(devConn), .disconnectPulse(devDisc));

  usb_line_event_det #(.CLK_MHZ(48), .UPSTREAM(1'b1)) u_usb_line_event_det_up (
    .clk(clk), .rst_n(rst_n), .dpHigh(dp), .dmHigh(dm), .lowSpeed(ls),
    .lineState(upLine), .sopPulse(upSop), .eopPulse(upEop),
    .busResetPulse(upRst), .connectPulse(upConn), .disconnectPulse(upDisc));

  int nRun = 0;
  int nFail = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  int modeBad = 0;

  typedef struct {int at; int mask;} exp_t;
  exp_t q[$];

  // mask bits: 0 sop (R3), 1 eop (R4), 2 reset (R5), 3 connect (R6), 4 disconnect (R7)
  function automatic string reqOf(int m);
    string s = "";
    if (m[0]) s = {s, "R3 "};
    if (m[1]) s = {s, "R4 "};
    if (m[2]) s = {s, "R5 "};
    if (m[3]) s = {s, "R6 "};
    if (m[4]) s = {s, "R7 "};
    if (s == "") s = "R10 ";
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic void push(int at, int mask);
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at == at) begin
        q[i].mask = q[i].mask | mask;
        return;
      end
      if (q[i].at > at) begin
        q.insert(i, '{at, mask});
        return;
      end
    end
    q.push_back('{at, mask});
  endfunction

  // Monitor: compare event pulses against the scoreboard
  always @(negedge clk) begin
    if (rst_n && monOn) begin
      int obs;
      obs = {27'd0, upDisc, upConn, devRst, devEop, devSop};
      if (devConn || devDisc || upRst) modeBad++;
      while (q.size() > 0 && q[0].at < cyc) begin
        check(1'b0, reqOf(q[0].mask), "missing event mask", 0, q[0].mask);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        check(obs == q[0].mask, reqOf(q[0].mask), "event mask", obs, q[0].mask);
        void'(q.pop_front());
      end else if (obs != 0) begin
        check(1'b0, {reqOf(obs), "R10"}, "unexpected event mask", obs, 0);
      end
    end
  end

  // Bench-side model state
  int prevCls = C_SE0;
  int se0Run = 0;
  int actRun = 0;
  bit connected = 1'b0;

  function automatic int classOf(bit p, bit m, bit slow);
    if (!p && !m) return C_SE0;
    if (p && m) return C_SE1;
    if (p) return slow ? C_K : C_J;
    return slow ? C_J : C_K;
  endfunction

  // Driver: hold a wire pair for len cycles (len >= 4), pushing expected events
  task automatic seg(bit p, bit m, bit slow, int len);
    int nc;
    int t;
    int start;
    nc = classOf(p, m, slow);
    t = cyc + 3;
    dp = p; dm = m; ls = slow;
    if (nc == C_K && prevCls == C_J) push(t, 1);
    if (nc == C_J && prevCls == C_SE0 && se0Run >= (slow ? LS_BIT : FS_BIT)) push(t, 2);
    if (nc == C_SE0) begin
      se0Run = len;
      actRun = 0;
      if (len >= LIM) begin
        push(t + LIM - 1, 4);
        if (connected) begin
          push(t + LIM - 1, 16);
          connected = 1'b0;
        end
      end
    end else begin
      start = (prevCls == C_SE0) ? 0 : actRun;
      actRun = start + len;
      se0Run = 0;
      if (!connected && start < LIM && start + len >= LIM) begin
        push(t + LIM - 1 - start, 8);
        connected = 1'b1;
      end
    end
    prevCls = nc;
    repeat (3) @(negedge clk);
    check(devLine == 2'(nc) && upLine == 2'(nc), slow ? "R2" : "R1", "line code", devLine, nc);
    repeat (len - 3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check(devLine == 2'b00 && upLine == 2'b00, "R9", "line code in reset", devLine, 0);
    check({devSop, devEop, devRst, devConn, devDisc, upSop, upEop, upRst, upConn, upDisc} == 10'd0,
          "R9", "events in reset", 1, 0);
    rst_n = 1'b1;
    monOn = 1'b1;

    // Full speed
    seg(1, 0, 0, 200);   // J idle, connect (R6)
    seg(0, 1, 0, 10);    // K: start of packet (R3)
    seg(1, 0, 0, 10);
    seg(0, 0, 0, 3);     // short SE0
    seg(1, 0, 0, 10);    // no end of packet (R4)
    seg(0, 0, 0, 4);     // exactly one bit
    seg(1, 0, 0, 10);    // end of packet (R4)
    seg(0, 1, 0, 6);     // start of packet
    seg(0, 0, 0, 5);
    seg(0, 1, 0, 6);     // SE0 to K: nothing (R3, R4)
    seg(1, 1, 0, 6);     // SE1 code (R1)
    seg(1, 0, 0, 10);
    seg(0, 0, 0, 119);   // just under reset / disconnect (R5, R7)
    seg(1, 0, 0, 150);   // end of packet only
    seg(0, 0, 0, 130);   // reset (R5) and disconnect (R7), once each
    seg(1, 0, 0, 20);    // end of packet
    seg(0, 1, 0, 110);   // start of packet, reconnect across segments (R6)

    // Low speed, mode switched during SE0
    seg(0, 0, 1, 10);
    seg(0, 1, 1, 10);    // J at low speed (R2), SE0 too short for end of packet
    seg(1, 0, 1, 10);    // K at low speed: start of packet
    seg(0, 1, 1, 10);
    seg(0, 0, 1, 31);    // below low-speed bit time
    seg(0, 1, 1, 10);    // no end of packet (R4)
    seg(0, 0, 1, 32);    // one low-speed bit time
    seg(0, 1, 1, 10);    // end of packet (R4)
    seg(1, 1, 1, 6);     // SE1 code unchanged (R2)
    seg(0, 1, 1, 150);   // drain

    check(q.size() == 0, "R5 R6 R7", "pending expected events", q.size(), 0);
    check(modeBad == 0, "R8", "events outside port side", modeBad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule